// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block finds out which kind of parallel NOR flash sits on a simple byte bus and which unlock address pair later command sequences must use. A start pulse makes it run a fixed list of bus operations. It resets the flash, issues an autoselect command and reads three identification bytes: manufacturer, device and protection. It then resets the flash again so that it leaves ID mode. The bytes are compared against a small table of known parts.

The first attempt uses the unlock pair 0xAAA/0x555 and matches on the manufacturer and the third byte. If that attempt gives no match, the block repeats the whole sequence with the pair 0x555/0x2AA and matches on the manufacturer and the device byte. The spacing of the three reads depends on whether the bus is wide.

When the run ends, the block pulses `done` and presents the chosen method, the ID bytes and an error code. These values stay unchanged until the next start.

Top module: `nor_id_probe`

## Requirements
- R1: After reset, `bus_req` and `done` are low, `method` is 0, `err_code` is 0, and `manuf_id`, `dev_id` and `prot_id` are 0xFF.
- R2: One cycle after an accepted `start`, `method` reads 0 (unknown), all three ID outputs read 0xFF and `err_code` reads 0.
- R3: The first attempt issues these bus operations, in this order:
  - write 0xF0 at address 0;
  - write 0xAA at 0xAAA;
  - write 0x55 at 0x555;
  - write 0x90 at 0xAAA;
  - read at 0, then at inc, then at 2·inc;
  - write 0xF0 at 0.
- R4: The stride inc is 2 when `wide` was high at start, and 1 otherwise.
- R5: Method A (`method`=1) is chosen after the first attempt when the manufacturer/third-byte pair is one of these:
  - 0x01 with 0xDA, 0x7E or 0xD6;
  - 0x20 with 0xD7 or 0xDE;
  - 0x04 with 0xDA or 0x4A;
  - 0xC2 with 0xDA.

  In that case no further bus operations follow.
- R6: If the first attempt finds no match, a second attempt of eight operations follows. Its layout is the same as in R3, with the unlock writes being 0xAA at 0x555, 0x55 at 0x2AA and 0x90 at 0x555.
- R7: Method B (`method`=2) is chosen after the second attempt in two cases:
  - the device byte is 0x3E and the manufacturer is 0x01, 0x04, 0x89 or 0xC2;
  - the device byte is 0xEA and the manufacturer is 0x20.
- R8: When neither attempt matches, `method` stays 0, the ID outputs stay 0xFF and `err_code` becomes 0x000700.
- R9: On success, the three bytes read in the matching attempt appear on `manuf_id`, `dev_id` and `prot_id`, and `err_code` is 0.
- R10: `done` is high for exactly one cycle, the cycle after the final reset write is acknowledged. From then on `bus_req` stays low.
- R11: A `start` while a run is in progress is ignored. Between `done` and the next `start`, all result outputs hold their values.
- R12: Once `bus_req` is raised, it stays high with address, direction and write data unchanged until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe when idle |
| wide | input | 1 | Flash bus is wide; read stride 2 |
| done | output | 1 | One-cycle end-of-probe pulse |
| bus_req | output | 1 | Bus operation requested |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Flash byte address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Operation complete; read data valid |
| bus_rdata | input | 8 | Read data |
| method | output | 2 | 0 unknown, 1 method A, 2 method B |
| manuf_id | output | 8 | Manufacturer byte |
| dev_id | output | 8 | Device byte |
| prot_id | output | 8 | Third ID byte |
| err_code | output | ERR_W | 0 on success, 0x000700 when not identified |

## Verification
A wrong step or attempt register changes the address or data of the very next bus operation. The bench records every operation and compares the list entry by entry against R3 and R6, so such a fault shows at its first misplaced transfer. A wrong captured byte or a bad table decision shows only at `done`, as a wrong `method`, ID value or `err_code`. A wrong stride shows up as autoselect reads landing at the wrong offsets, which the flash model answers with unrelated data.

// File: rtl/nor_id_probe.sv
module nor_id_probe #(
  parameter int ADDR_W = 16,
  parameter int ERR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  output logic              done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  output logic [1:0]        method,
  output logic [7:0]        manuf_id,
  output logic [7:0]        dev_id,
  output logic [7:0]        prot_id,
  output logic [ERR_W-1:0]  err_code
);
  localparam logic [1:0] M_NONE = 2'd0;
  localparam logic [1:0] M_A    = 2'd1;
  localparam logic [1:0] M_B    = 2'd2;
  localparam logic [7:0] CMD_RST = 8'hF0;
  localparam logic [ERR_W-1:0] ERR_NOID = ERR_W'('h700);
  localparam logic [ADDR_W-1:0] ADR_0   = '0;
  localparam logic [ADDR_W-1:0] ADR_AAA = ADDR_W'('hAAA);
  localparam logic [ADDR_W-1:0] ADR_555 = ADDR_W'('h555);
  localparam logic [ADDR_W-1:0] ADR_2AA = ADDR_W'('h2AA);

  logic       running, alt, wide_q;
  logic [2:0] step;
  logic [7:0] cap_m, cap_d, cap_p;
  logic [ADDR_W-1:0] stride, unl_hi, unl_lo;
  logic       hit_a, hit_b, last_op;

  assign stride  = wide_q ? ADDR_W'(2) : ADDR_W'(1);
  assign unl_hi  = alt ? ADR_555 : ADR_AAA;
  assign unl_lo  = alt ? ADR_2AA : ADR_555;
  assign bus_req = running;
  assign last_op = running && bus_ack && (step == 3'd7);

  always_comb begin
    bus_we = 1'b1;
    bus_addr = ADR_0;
    bus_wdata = 8'h00;
    case (step)
      3'd0: bus_wdata = CMD_RST;
      3'd1: begin bus_addr = unl_hi; bus_wdata = 8'hAA; end
      3'd2: begin bus_addr = unl_lo; bus_wdata = 8'h55; end
      3'd3: begin bus_addr = unl_hi; bus_wdata = 8'h90; end
      3'd4: bus_we = 1'b0;
      3'd5: begin bus_we = 1'b0; bus_addr = stride; end
      3'd6: begin bus_we = 1'b0; bus_addr = stride + stride; end
      default: bus_wdata = CMD_RST;
    endcase
  end

  assign hit_a = (cap_m == 8'h01 && (cap_p == 8'hDA || cap_p == 8'h7E || cap_p == 8'hD6)) ||
                 (cap_m == 8'h20 && (cap_p == 8'hD7 || cap_p == 8'hDE)) ||
                 (cap_m == 8'h04 && (cap_p == 8'hDA || cap_p == 8'h4A)) ||
                 (cap_m == 8'hC2 &&  cap_p == 8'hDA);
  assign hit_b = (cap_d == 8'h3E && (cap_m == 8'h01 || cap_m == 8'h04 ||
                                     cap_m == 8'h89 || cap_m == 8'hC2)) ||
                 (cap_d == 8'hEA && cap_m == 8'h20);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; alt <= 1'b0; wide_q <= 1'b0; step <= '0; done <= 1'b0;
      cap_m <= 8'hFF; cap_d <= 8'hFF; cap_p <= 8'hFF;
      method <= M_NONE; manuf_id <= 8'hFF; dev_id <= 8'hFF; prot_id <= 8'hFF;
      err_code <= '0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1; alt <= 1'b0; step <= '0; wide_q <= wide;
          method <= M_NONE; manuf_id <= 8'hFF; dev_id <= 8'hFF; prot_id <= 8'hFF;
          err_code <= '0;
        end
      end else if (bus_ack) begin
        if (step == 3'd4) cap_m <= bus_rdata;
        if (step == 3'd5) cap_d <= bus_rdata;
        if (step == 3'd6) cap_p <= bus_rdata;
        if (step != 3'd7) begin
          step <= step + 3'd1;
        end else if (alt ? hit_b : hit_a) begin
          running <= 1'b0; done <= 1'b1;
          method <= alt ? M_B : M_A;
          manuf_id <= cap_m; dev_id <= cap_d; prot_id <= cap_p;
        end else if (!alt) begin
          alt <= 1'b1; step <= '0;
        end else begin
          running <= 1'b0; done <= 1'b1; err_code <= ERR_NOID;
        end
      end
    end
  end

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_after_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_req && bus_ack && bus_we && bus_wdata == CMD_RST && bus_addr == ADR_0));
  a_r10_bus_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);
  a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && !start) |=> ($stable(method) && $stable(err_code) && $stable(manuf_id)));
  a_r8_fail_leaves_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != '0) |-> (method == M_NONE && manuf_id == 8'hFF && dev_id == 8'hFF));
  a_r9_success_has_method: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == '0) |-> (method == M_A || method == M_B));
  a_r2_start_presets: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && start) |=> (method == M_NONE && prot_id == 8'hFF && err_code == '0));
endmodule

// File: tb/nor_id_probe_test.sv
module nor_id_probe_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0;
  logic done, bus_req, bus_we, bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 8'h00;
  logic [1:0] method;
  logic [7:0] manuf_id, dev_id, prot_id;
  logic [23:0] err_code;

  int checks = 0, failures = 0;

  nor_id_probe #(.ADDR_W(AW), .ERR_W(24)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .done(done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .method(method), .manuf_id(manuf_id),
    .dev_id(dev_id), .prot_id(prot_id), .err_code(err_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  // flash model configuration and transaction log
  logic [7:0] chip_m, chip_d, chip_p;
  logic chip_wide, acc_a, acc_b, idm;
  int lat, cnt;
  logic lg_we [0:31];
  logic [AW-1:0] lg_addr [0:31];
  logic [7:0] lg_dat [0:31];
  int lg_n;
  logic [AW-1:0] p1_a, p2_a;
  logic [7:0] p1_d, p2_d;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] id_read(input logic [AW-1:0] a);
    logic [AW-1:0] inc;
    inc = chip_wide ? 2 : 1;
    if (!idm) return 8'hFF;
    if (a == 0) return chip_m;
    if (a == inc) return chip_d;
    if (a == inc + inc) return chip_p;
    return 8'h00;
  endfunction

  initial begin
    idm = 0; cnt = 0; lg_n = 0; lat = 0;
    p1_a = '0; p2_a = '0; p1_d = '0; p2_d = '0;
    forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (cnt < lat) cnt++;
        else begin
          cnt = 0; bus_ack = 1'b1;
          if (lg_n < 32) begin
            lg_we[lg_n] = bus_we; lg_addr[lg_n] = bus_addr; lg_dat[lg_n] = bus_wdata;
          end
          lg_n++;
          if (bus_we) begin
            if (bus_wdata == 8'hF0) idm = 0;
            else if (bus_wdata == 8'h90 && p2_d == 8'hAA && p1_d == 8'h55 && p2_a == bus_addr &&
                     ((bus_addr == 16'hAAA && p1_a == 16'h555 && acc_a) ||
                      (bus_addr == 16'h555 && p1_a == 16'h2AA && acc_b))) idm = 1;
            p2_a = p1_a; p2_d = p1_d; p1_a = bus_addr; p1_d = bus_wdata;
          end else bus_rdata = id_read(bus_addr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int expect_method(input logic [7:0] m, d, p, input logic aa, ab);
    if (aa && ((m == 8'h01 && (p == 8'hDA || p == 8'h7E || p == 8'hD6)) ||
               (m == 8'h20 && (p == 8'hD7 || p == 8'hDE)) ||
               (m == 8'h04 && (p == 8'hDA || p == 8'h4A)) ||
               (m == 8'hC2 && p == 8'hDA))) return 1;
    if (ab && ((d == 8'h3E && (m == 8'h01 || m == 8'h04 || m == 8'h89 || m == 8'hC2)) ||
               (d == 8'hEA && m == 8'h20))) return 2;
    return 0;
  endfunction

  task automatic run_probe(input string name, input logic [7:0] m, d, p,
                           input logic w, input int l, input logic aa, ab, input bit poke);
    int em, n_exp, waited;
    logic [AW-1:0] inc, hi, lo, ea;
    logic ew;
    logic [7:0] ed;
    chip_m = m; chip_d = d; chip_p = p; chip_wide = w; acc_a = aa; acc_b = ab; lat = l;
    em = expect_method(m, d, p, aa, ab);
    n_exp = (em == 1) ? 8 : 16;
    inc = w ? 2 : 1;
    @(negedge clk);
    lg_n = 0; wide = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(method == 0 && manuf_id == 8'hFF && dev_id == 8'hFF && prot_id == 8'hFF && err_code == 0,
        {name, " R2 presets"}, {manuf_id, dev_id, prot_id}, 24'hFFFFFF);
    waited = 0;
    while (!done && waited < 400) begin
      if (poke && waited == 5) start = 1'b1;
      if (poke && waited == 6) start = 1'b0;
      @(negedge clk); waited++;
    end
    start = 1'b0;
    chk(done, {name, " R10 done seen"}, done, 1);
    chk(lg_n == n_exp, {name, " R3/R6 op count, R11 no restart"}, lg_n, n_exp);
    for (int i = 0; i < 16 && i < lg_n && i < n_exp; i++) begin
      hi = (i >= 8) ? 16'h555 : 16'hAAA;
      lo = (i >= 8) ? 16'h2AA : 16'h555;
      ew = 1; ed = 8'hF0; ea = 0;
      case (i % 8)
        1: begin ea = hi; ed = 8'hAA; end
        2: begin ea = lo; ed = 8'h55; end
        3: begin ea = hi; ed = 8'h90; end
        4: begin ew = 0; ea = 0; end
        5: begin ew = 0; ea = inc; end
        6: begin ew = 0; ea = inc + inc; end
        default: ;
      endcase
      chk(lg_we[i] == ew && lg_addr[i] == ea && (!ew || lg_dat[i] == ed),
          {name, (i >= 8) ? " R6 op" : " R3 op", " (R4 stride)"},
          {lg_we[i], lg_addr[i], lg_dat[i]}, {ew, ea, ed});
    end
    chk(method == 2'(em), {name, (em == 2) ? " R7 method" : " R5 method"}, method, em);
    if (em != 0) begin
      chk(err_code == 0 && manuf_id == m && dev_id == d && prot_id == p,
          {name, " R9 ids"}, {manuf_id, dev_id, prot_id}, {m, d, p});
    end else begin
      chk(err_code == 24'h000700 && manuf_id == 8'hFF && dev_id == 8'hFF && prot_id == 8'hFF,
          {name, " R8 no id"}, err_code, 24'h000700);
    end
    @(negedge clk);
    chk(!done && !bus_req, {name, " R10 single pulse"}, {done, bus_req}, 0);
    repeat (4) @(negedge clk);
    chk(method == 2'(em) && !bus_req && lg_n == n_exp, {name, " R11 hold"}, method, em);
  endtask

  task automatic test_reset;
    chk(!bus_req && !done && method == 0 && err_code == 0 &&
        manuf_id == 8'hFF && dev_id == 8'hFF && prot_id == 8'hFF,
        "R1 reset state", {bus_req, done, method}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    run_probe("A01",   8'h01, 8'h22, 8'hDA, 0, 0, 1, 1, 0);
    run_probe("A20w",  8'h20, 8'h11, 8'hDE, 1, 2, 1, 1, 0);
    run_probe("A04",   8'h04, 8'h00, 8'h4A, 0, 1, 1, 1, 1);
    run_probe("AC2w",  8'hC2, 8'h33, 8'hDA, 1, 0, 1, 1, 0);
    run_probe("A01b",  8'h01, 8'h00, 8'hD6, 0, 0, 1, 1, 0);
    run_probe("B01",   8'h01, 8'h3E, 8'h00, 0, 0, 1, 1, 0);
    run_probe("B20w",  8'h20, 8'hEA, 8'h00, 1, 1, 1, 1, 1);
    run_probe("B89",   8'h89, 8'h3E, 8'h01, 0, 0, 0, 1, 0);
    run_probe("BC2w",  8'hC2, 8'h3E, 8'h55, 1, 2, 1, 1, 0);
    run_probe("Nunk",  8'h55, 8'h3E, 8'hDA, 0, 0, 1, 1, 0);
    run_probe("NnoB",  8'h01, 8'h3E, 8'h00, 0, 0, 1, 0, 0);
    run_probe("Nxman", 8'h20, 8'h3E, 8'hDA, 1, 0, 1, 1, 0);
    run_probe("A01c",  8'h01, 8'h00, 8'h7E, 1, 0, 1, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule